// File: doc/BRIEF.md
# Module Clock Enable Controller

This block sits between a register bus and a group of peripheral modules. It decides which modules receive a functional clock, and it reports how far each module has got in leaving or entering idle. Every module has a control word. Software writes a two-bit mode into that word and then polls a two-bit idle-status field. The field reaches "functional" only after the module returns its acknowledge. A separate source-select word per module holds the clock-source choice, and the block passes that choice to the clock muxes outside it.

One domain word holds a two-bit transition-control field. When software writes the wake-up code and at least one module is enabled, three domain activity flags come up one after another, one per cycle. This models the domain's clocks starting in turn. The flags drop as soon as the wake request is withdrawn or no module is enabled any more. The block produces only enable levels. The clock generators, the glitch-free gating cells and the power switches are outside it.

Word addresses: control word of module i at index i, source word of module i at index NUM_MOD+i, domain word at index 2*NUM_MOD. With the defaults (NUM_MOD = 4) these are indices 0 to 3, 4 to 7 and 8. The read port is combinational. A write takes effect at the clock edge where `wr_en` is high.

Top module: `mcc_top`

## Requirements
- R1: After reset every control word reads 0x00030000 (mode 0, idle-status 3, debounce bit clear), every source word reads 0, and the domain word reads 0.
- R2: Control bits [1:0] hold the mode and read back exactly as written. Only mode 2 enables a module: `mod_clk_en` is high for a module while its sequence is in the wake or functional phase.
- R3: After mode 2 is written to a disabled module, its idle-status reads 3 until the write edge, reads 1 from the next edge, stays 1 while `mod_ack` is low, and reads 0 one edge after `mod_ack` is seen high.
- R4: Writing any mode other than 2 to an enabled module makes idle-status read 1 for DISABLE_DELAY cycles (default 4), starting one edge after the write, and then 3. At the same point the module's clock enable drops.
- R5: Modes 1 and 3 are reserved. A disabled module written with either value keeps idle-status 3 and `mod_clk_en` low, whatever its acknowledge does.
- R6: Bit 18 of a control word is the debounce-clock enable. It is stored only for modules selected in DB_MASK (default modules 1 and 2) and reads 0 on the others. `mod_dbclk_en` is that bit ANDed with the module's clock enable.
- R7: Source word bits [1:0] read back as written and appear on `mod_src` (two bits per module, module i at bits [2i+1:2i]). The codes are 0 for the external clock pin, 1 for the main oscillator and 2 for the 32 kHz clock.
- R8: Domain word bits [1:0] hold the transition-control field, readable and writable. Code 2 requests a software-forced wake-up.
- R9: Domain activity flags sit at bits 4, 5 and 6 and are read-only. Once the wake code is held and any module holds mode 2, bit 4 sets at the next edge, bit 5 one edge later and bit 6 one edge after that. All three read 0 before then.
- R10: All activity flags clear at the first edge where the wake code is absent or no module holds mode 2.
- R11: Bits outside the defined fields, and words at unmapped addresses, read as zero. Writes to unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for the word at `addr` |
| addr | input | ADDR_W | Word index for both read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data of the word at `addr` |
| mod_ack | input | NUM_MOD | Per-module acknowledge that the module has left idle |
| mod_clk_en | output | NUM_MOD | Per-module functional clock enable |
| mod_dbclk_en | output | NUM_MOD | Per-module debounce clock enable |
| mod_src | output | 2*NUM_MOD | Per-module clock source select |

## Verification
The assertions assume that `mod_ack` may change in any cycle and may even be high while a module is disabled. They therefore tie idle-status progress only to the mode and to an acknowledge seen one edge earlier, and they never require an acknowledge to arrive. The bench holds acknowledges low on purpose to show the wait, raises them at a negative edge to release it, and also leaves them high while reserved modes are written. The random phase writes arbitrary 32-bit words to every address, including unmapped ones, with acknowledges drawn at random. It compares only the stored fields, because the timed fields (idle-status and activity) are covered by the directed cycle counts.

// File: rtl/mcc_pkg.sv
`timescale 1ns/1ps
package mcc_pkg;

  typedef enum logic [1:0] {
    SEQ_OFF   = 2'd0,
    SEQ_WAKE  = 2'd1,
    SEQ_ON    = 2'd2,
    SEQ_DRAIN = 2'd3
  } seq_state_e;

  localparam logic [1:0] MODE_ENABLE = 2'd2;
  localparam logic [1:0] TCTL_WAKE   = 2'd2;

  localparam int IDLE_LSB = 16;
  localparam int DB_BIT   = 18;
  localparam int ACT_LSB  = 4;
  localparam int NUM_ACT  = 3;

  localparam logic [1:0] IDLE_FUNC  = 2'd0;
  localparam logic [1:0] IDLE_TRANS = 2'd1;
  localparam logic [1:0] IDLE_OFF   = 2'd3;

  function automatic logic [1:0] idle_code(seq_state_e s);
    case (s)
      SEQ_OFF: idle_code = IDLE_OFF;
      SEQ_ON:  idle_code = IDLE_FUNC;
      default: idle_code = IDLE_TRANS;
    endcase
  endfunction

endpackage

// File: rtl/mcc_rst_sync.sv
`timescale 1ns/1ps
module mcc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/mcc_mod_seq.sv
`timescale 1ns/1ps
module mcc_mod_seq
  import mcc_pkg::*;
#(
  parameter int DISABLE_DELAY = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       ack,
  output logic [1:0] idle,
  output logic       clk_req
);

  localparam int CW = $clog2(DISABLE_DELAY + 1);
  localparam logic [CW-1:0] LAST = CW'(DISABLE_DELAY - 1);

  seq_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      SEQ_OFF: begin
        if (enable) state_d = SEQ_WAKE;
      end
      SEQ_WAKE: begin
        if (!enable) begin
          state_d = SEQ_DRAIN;
          cnt_d   = '0;
        end else if (ack) begin
          state_d = SEQ_ON;
        end
      end
      SEQ_ON: begin
        if (!enable) begin
          state_d = SEQ_DRAIN;
          cnt_d   = '0;
        end
      end
      default: begin
        if (enable)             state_d = SEQ_WAKE;
        else if (cnt_q == LAST) state_d = SEQ_OFF;
        else                    cnt_d   = cnt_q + 1'b1;
      end
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_OFF;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign idle    = idle_code(state_q);
  assign clk_req = (state_q == SEQ_WAKE) || (state_q == SEQ_ON);

endmodule

// File: rtl/mcc_domain.sv
`timescale 1ns/1ps
module mcc_domain #(
  parameter int NUM_ACT = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wake_req,
  input  logic               any_on,
  output logic [NUM_ACT-1:0] act
);

  logic               run;
  logic [NUM_ACT-1:0] act_q, act_d;

  assign run = wake_req & any_on;

  // each clock reports running one cycle after the one before it
  genvar k;
  generate
    for (k = 0; k < NUM_ACT; k++) begin : g_stage
      if (k == 0) begin : g_first
        assign act_d[k] = run;
      end else begin : g_next
        assign act_d[k] = run & act_q[k-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= '0;
    else        act_q <= act_d;
  end

  assign act = act_q;

endmodule

// File: rtl/mcc_top.sv
`timescale 1ns/1ps
module mcc_top
  import mcc_pkg::*;
#(
  parameter int                 NUM_MOD       = 4,
  parameter int                 ADDR_W        = 4,
  parameter int                 DISABLE_DELAY = 4,
  parameter logic [NUM_MOD-1:0] DB_MASK       = 4'b0110
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  input  logic [NUM_MOD-1:0]   mod_ack,
  output logic [NUM_MOD-1:0]   mod_clk_en,
  output logic [NUM_MOD-1:0]   mod_dbclk_en,
  output logic [2*NUM_MOD-1:0] mod_src
);

  localparam int SRC_BASE = NUM_MOD;
  localparam int DOM_IDX  = 2 * NUM_MOD;

  logic rst_sync_n;

  logic [NUM_MOD-1:0][1:0] mode_q, mode_d;
  logic [NUM_MOD-1:0]      db_q, db_d;
  logic [NUM_MOD-1:0][1:0] src_q, src_d;
  logic [1:0]              tctl_q, tctl_d;

  logic [NUM_MOD-1:0][1:0] idle_vec;
  logic [NUM_MOD-1:0]      mod_on;
  logic [NUM_ACT-1:0]      act_vec;

  logic unused_wdata;
  assign unused_wdata = ^{wdata[31:19], wdata[17:2]};

  mcc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // write decode, next-state
  always_comb begin
    mode_d = mode_q;
    db_d   = db_q;
    src_d  = src_q;
    tctl_d = tctl_q;
    if (wr_en) begin
      for (int i = 0; i < NUM_MOD; i++) begin
        if (addr == ADDR_W'(i)) begin
          mode_d[i] = wdata[1:0];
          db_d[i]   = wdata[DB_BIT] & DB_MASK[i];
        end
        if (addr == ADDR_W'(SRC_BASE + i)) begin
          src_d[i] = wdata[1:0];
        end
      end
      if (addr == ADDR_W'(DOM_IDX)) tctl_d = wdata[1:0];
    end
  end

  // register process with explicit write enable
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mode_q <= '0;
      db_q   <= '0;
      src_q  <= '0;
      tctl_q <= '0;
    end else if (wr_en) begin
      mode_q <= mode_d;
      db_q   <= db_d;
      src_q  <= src_d;
      tctl_q <= tctl_d;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_MOD; g++) begin : g_mod
      logic en;
      assign en = (mode_q[g] == MODE_ENABLE);

      mcc_mod_seq #(.DISABLE_DELAY(DISABLE_DELAY)) u_seq (
        .clk     (clk),
        .rst_n   (rst_sync_n),
        .enable  (en),
        .ack     (mod_ack[g]),
        .idle    (idle_vec[g]),
        .clk_req (mod_clk_en[g])
      );

      assign mod_on[g]         = en;
      assign mod_dbclk_en[g]   = db_q[g] & mod_clk_en[g];
      assign mod_src[2*g +: 2] = src_q[g];
    end
  endgenerate

  mcc_domain #(.NUM_ACT(NUM_ACT)) u_dom (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wake_req (tctl_q == TCTL_WAKE),
    .any_on   (|mod_on),
    .act      (act_vec)
  );

  // read mux
  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_MOD; i++) begin
      if (addr == ADDR_W'(i)) begin
        rdata[1:0]                  = mode_q[i];
        rdata[IDLE_LSB +: 2]        = idle_vec[i];
        rdata[DB_BIT]               = db_q[i];
      end
      if (addr == ADDR_W'(SRC_BASE + i)) rdata[1:0] = src_q[i];
    end
    if (addr == ADDR_W'(DOM_IDX)) begin
      rdata[1:0]                = tctl_q;
      rdata[ACT_LSB +: NUM_ACT] = act_vec;
    end
  end

endmodule

// File: rtl/mcc_checker.sv
`timescale 1ns/1ps
module mcc_checker #(
  parameter int NUM_MOD = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NUM_MOD-1:0][1:0] mode,
  input logic [NUM_MOD-1:0][1:0] idle,
  input logic [NUM_MOD-1:0]      ack,
  input logic [1:0]              tctl,
  input logic [2:0]              act
);

  genvar i;
  generate
    for (i = 0; i < NUM_MOD; i++) begin : g_chk
      a_r3_no_skip_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (idle[i] == 2'd3) |=> (idle[i] != 2'd0));

      a_r3_hold_without_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (idle[i] == 2'd1 && !ack[i] && mode[i] == 2'd2) |=> (idle[i] == 2'd1));

      a_r4_leave_functional: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[i] != 2'd2) |=> (idle[i] != 2'd0));

      a_r5_reserved_stays_off: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[i] != 2'd2 && idle[i] == 2'd3) |=> (idle[i] == 2'd3));
    end
  endgenerate

  a_r9_act_order_hi: assert property (@(posedge clk) disable iff (!rst_n)
    act[2] |-> act[1]);

  a_r9_act_order_lo: assert property (@(posedge clk) disable iff (!rst_n)
    act[1] |-> act[0]);

  a_r10_clear_without_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (tctl != 2'd2) |=> (act == 3'b000));

endmodule

bind mcc_top mcc_checker #(.NUM_MOD(NUM_MOD)) u_chk (
  .clk  (clk),
  .rst_n(rst_sync_n),
  .mode (mode_q),
  .idle (idle_vec),
  .ack  (mod_ack),
  .tctl (tctl_q),
  .act  (act_vec)
);

// File: tb/mcc_top_tb.sv
`timescale 1ns/1ps
module mcc_top_tb;

  localparam int NUM_MOD = 4;
  localparam int ADDR_W  = 4;
  localparam logic [NUM_MOD-1:0] DBM = 4'b0110;

  logic                 clk;
  logic                 rst_n;
  logic                 wr_en;
  logic [ADDR_W-1:0]    addr;
  logic [31:0]          wdata;
  logic [31:0]          rdata;
  logic [NUM_MOD-1:0]   mod_ack;
  logic [NUM_MOD-1:0]   mod_clk_en;
  logic [NUM_MOD-1:0]   mod_dbclk_en;
  logic [2*NUM_MOD-1:0] mod_src;

  int n_cmp;
  int n_bad;
  bit done;

  logic [1:0] m_mode [NUM_MOD];
  logic       m_db   [NUM_MOD];
  logic [1:0] m_src  [NUM_MOD];
  logic [1:0] m_tctl;

  mcc_top u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .addr         (addr),
    .wdata        (wdata),
    .rdata        (rdata),
    .mod_ack      (mod_ack),
    .mod_clk_en   (mod_clk_en),
    .mod_dbclk_en (mod_dbclk_en),
    .mod_src      (mod_src)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    addr  = a;
    wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  // stored fields predicted from the requirements
  function automatic logic [31:0] model_word(input int a);
    logic [31:0] w;
    w = '0;
    if (a < NUM_MOD) begin
      w[1:0] = m_mode[a];
      w[18]  = m_db[a];
    end else if (a < 2 * NUM_MOD) begin
      w[1:0] = m_src[a - NUM_MOD];
    end else if (a == 2 * NUM_MOD) begin
      w[1:0] = m_tctl;
    end
    return w;
  endfunction

  function automatic logic [31:0] timed_mask(input int a);
    if (a < NUM_MOD)       return 32'h0003_0000;
    if (a == 2 * NUM_MOD)  return 32'h0000_0070;
    return 32'h0;
  endfunction

  function automatic string req_of(input int a);
    if (a < NUM_MOD)      return "R2";
    if (a < 2 * NUM_MOD)  return "R7";
    if (a == 2 * NUM_MOD) return "R8";
    return "R11";
  endfunction

  task automatic model_write(input int a, input logic [31:0] d);
    if (a < NUM_MOD) begin
      m_mode[a] = d[1:0];
      m_db[a]   = d[18] & DBM[a];
    end else if (a < 2 * NUM_MOD) begin
      m_src[a - NUM_MOD] = d[1:0];
    end else if (a == 2 * NUM_MOD) begin
      m_tctl = d[1:0];
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    n_cmp = 0;
    n_bad = 0;
    done  = 1'b0;
    wr_en = 1'b0;
    addr  = '0;
    wdata = '0;
    mod_ack = '0;
    rst_n = 1'b0;
    void'($urandom(32'h1234_abcd));
    for (int i = 0; i < NUM_MOD; i++) begin
      m_mode[i] = 2'd0; m_db[i] = 1'b0; m_src[i] = 2'd0;
    end
    m_tctl = 2'd0;
    step(5);
    rst_n = 1'b1;
    step(5);

    // R1 reset state
    for (int i = 0; i < NUM_MOD; i++) begin
      rd(ADDR_W'(i), r);           chk("R1 ctrl", r, 32'h0003_0000);
      rd(ADDR_W'(NUM_MOD + i), r); chk("R1 src", r, 32'h0);
    end
    rd(ADDR_W'(2 * NUM_MOD), r);   chk("R1 domain", r, 32'h0);

    // R3 enable handshake, ack held low
    wr(0, 32'h2);
    rd(0, r); chk("R3 before edge", r, 32'h0003_0002);
    step(1); rd(0, r); chk("R3 transition", r, 32'h0001_0002);
    step(3); rd(0, r); chk("R3 waits for ack", r, 32'h0001_0002);
    chk("R2 clk_en while waking", 32'(mod_clk_en[0]), 32'h1);
    mod_ack[0] = 1'b1;
    step(1); rd(0, r); chk("R3 functional", r, 32'h0000_0002);

    // R4 disable timing
    wr(0, 32'h0);
    rd(0, r); chk("R4 at write edge", r, 32'h0000_0000);
    step(4); rd(0, r); chk("R4 draining", r, 32'h0001_0000);
    step(1); rd(0, r); chk("R4 disabled", r, 32'h0003_0000);
    chk("R4 clk_en off", 32'(mod_clk_en[0]), 32'h0);

    // R5 reserved modes with ack high
    mod_ack = '1;
    wr(2, 32'h1);
    step(8); rd(2, r); chk("R5 mode 1", r, 32'h0003_0001);
    chk("R5 clk_en mode 1", 32'(mod_clk_en[2]), 32'h0);
    wr(2, 32'h3);
    step(8); rd(2, r); chk("R5 mode 3", r, 32'h0003_0003);

    // R6 debounce bit
    wr(1, 32'h0004_0002);
    step(3); rd(1, r); chk("R6 db kept", r, 32'h0004_0002);
    chk("R6 dbclk_en", 32'(mod_dbclk_en[1]), 32'h1);
    wr(0, 32'h0004_0002);
    step(3); rd(0, r); chk("R6 db dropped", r, 32'h0000_0002);
    chk("R6 dbclk_en off", 32'(mod_dbclk_en[0]), 32'h0);
    wr(0, 32'h0);
    wr(1, 32'h0);
    step(6);

    // R11 undefined bits and unmapped words
    wr(3, 32'hFFFF_FFFF);
    step(6); rd(3, r); chk("R11 ctrl undefined bits", r, 32'h0003_0003);
    wr(15, 32'hFFFF_FFFF);
    rd(15, r); chk("R11 unmapped", r, 32'h0);
    wr(3, 32'h0);

    // R7 source select
    wr(4, 32'h2);
    rd(4, r); chk("R7 src 32k", r, 32'h2);
    chk("R7 mod_src", 32'(mod_src[1:0]), 32'h2);
    wr(5, 32'hFFFF_FFFD);
    rd(5, r); chk("R7 src osc", r, 32'h1);

    // R9 activity sequence
    wr(3, 32'h2);
    step(3);
    rd(8, r); chk("R9 no wake yet", r, 32'h0);
    wr(8, 32'h2);
    rd(8, r); chk("R8 wake readback", r, 32'h2);
    step(1); rd(8, r); chk("R9 first clock", r, 32'h12);
    step(1); rd(8, r); chk("R9 second clock", r, 32'h32);
    step(1); rd(8, r); chk("R9 third clock", r, 32'h72);

    // R10 clear on last module off, then on wake withdrawn
    wr(3, 32'h0);
    rd(8, r); chk("R10 before edge", r, 32'h72);
    step(1); rd(8, r); chk("R10 no module", r, 32'h02);
    wr(3, 32'h2);
    step(3);
    rd(8, r); chk("R9 rebuilt", r, 32'h72);
    wr(8, 32'h0);
    rd(8, r); chk("R10 wake dropped edge", r, 32'h70);
    step(1); rd(8, r); chk("R10 wake dropped", r, 32'h00);
    wr(3, 32'h0);
    wr(4, 32'h0);
    wr(5, 32'h0);
    step(6);
    for (int i = 0; i < NUM_MOD; i++) begin
      m_mode[i] = 2'd0; m_db[i] = 1'b0; m_src[i] = 2'd0;
    end
    m_tctl = 2'd0;

    // constrained random field check
    for (int it = 0; it < 300; it++) begin
      int a;
      logic [31:0] d;
      a = int'($urandom_range(0, (1 << ADDR_W) - 1));
      d = $urandom;
      if (($urandom_range(0, 3)) == 0) d[1:0] = 2'd2;
      mod_ack = NUM_MOD'($urandom);
      wr(ADDR_W'(a), d);
      model_write(a, d);
      rd(ADDR_W'(a), r);
      chk(req_of(a), r & ~timed_mask(a), model_word(a));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule